// File: doc/BRIEF.md
# Frame-Start Shadow Register Bank

This block holds the configuration of a streaming video pipeline. Software programs it through a simple single-cycle register bus. Some fields are shadowed. For those, the value software writes is the programmed copy, and the datapath sees a separate working copy. The working copy takes the programmed value only when a frame-start (FS) marker reaches the pipeline stage that uses the field. As a result, software can prepare the next frame while the current one is still streaming. Fields that are not shadowed reach the datapath on the cycle after the write, whether or not traffic is flowing.

There are four kinds of frame-start event:
- an input-stage pulse;
- an output-stage pulse;
- a video-port pulse;
- a tagged event that carries a 5-bit source port number, used by the write contexts.

A write context changes its mode only when the tag matches the port number held in that same context's register. A separate early frame-start pulse comes from the protocol layer up to 8 cycles ahead of the stage markers. It sets a sticky status bit, and an enable mask gates that bit onto the interrupt pin. The bus readback shows programmed values. A second read port shows the working copies for debug.

All pins are plain control and status signals. No stream data passes through the block, so it has no valid/ready handshake and applies no back-pressure.

Top module: `shadow_bank`

## Requirements
- R1: Non-shadowed bits take effect on the cycle after the write, whatever FS activity there is. These are:
  - the frame-start reset bit, bit 31 of word 2;
  - bits 31:2 of each context word (8+k);
  - the interrupt mask, bit 0 of word 4.
- R2: The bypass enable (word 0 bit 31) and the input port (word 1 bits 4:0) reach the working outputs only on a cycle with `fs_in` high.
- R3: Four groups of bypass fields reach the working outputs only on a cycle with `fs_out` high:
  - vertical blanking (word 0 bits 30:25);
  - horizontal blanking (bits 24:17);
  - pixel clock divider (bits 16:0);
  - word 1's duplicate bit (10) and output port (9:5).
- R4: Word 2 bits 30:0 reach `vp_cfg` only on a cycle with `fs_vp` high.
- R5: The mode of context k (word 8+k, bits 1:0) is loaded only on a cycle with `fs_tag_vld` high and `fs_tag_port` equal to bits 13:9 of that context word.
- R6: When a write and a loading FS fall in the same cycle, the working copy takes the value programmed before the write. The new value waits for the next FS.
- R7: `reg_rdata` returns the programmed value of the addressed word; bits a word does not hold read 0. `dbg_rdata` returns the working copies in the same layout. Word 2 bit 31 and the context bits 31:2 read their immediate values. Unused addresses read 0.
- R8: Interrupt status and output:
  - `fs_early` sets the status bit (word 3 bit 0).
  - Writing 1 to that bit clears it, but a set in the same cycle wins.
  - `irq` is the status ANDed with the mask.
- R9: Reset clears every programmed and working copy and the status bit. No working copy leaves zero before its first loading FS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_waddr | input | AW | Write word address |
| reg_wdata | input | 32 | Write data |
| reg_raddr | input | AW | Readback address |
| reg_rdata | output | 32 | Programmed value at reg_raddr |
| dbg_raddr | input | AW | Debug read address |
| dbg_rdata | output | 32 | Working value at dbg_raddr |
| fs_in | input | 1 | Frame start seen at the bypass input stage |
| fs_out | input | 1 | Frame start seen at the bypass output stage |
| fs_vp | input | 1 | Frame start seen at the video port |
| fs_tag_vld | input | 1 | Tagged frame start for the write contexts |
| fs_tag_port | input | 5 | Source port number of the tagged frame start |
| fs_early | input | 1 | Early frame start from the protocol layer |
| byp_en | output | 1 | Working bypass enable |
| byp_port_in | output | 5 | Working bypass input port |
| byp_vblank | output | 6 | Working vertical blanking |
| byp_hblank | output | 8 | Working horizontal blanking |
| byp_pclk | output | 17 | Working pixel clock divider |
| byp_dup | output | 1 | Working duplicate-data flag |
| byp_port_out | output | 5 | Working bypass output port |
| vp_cfg | output | 31 | Working video port control |
| vp_fs_reset | output | 1 | Immediate frame-start reset bit |
| ctx_mode | output | 2*NCTX | Working mode of each write context |
| ctx_misc | output | 30*NCTX | Immediate bits 31:2 of each context word |
| irq | output | 1 | Gated frame-start interrupt |

## Verification
The bench aims at several corner cases, and each catches a specific kind of fault:
- A write that lands in the same cycle as an FS: a design that lets the new value through reveals it on the working outputs one frame early.
- Bypass word 0 and word 1 each split across two FS events: a design that ties a whole word to one event moves the blanking fields on `fs_in`, or the enable on `fs_out`.
- Tagged events whose port matches one context and differs from the rest: the match must come from the port bits of that context's own register, so a design that compares against the wrong register reloads the wrong context.
- An early pulse that collides with a write-1 clear: a design that gives the clear priority loses the interrupt.

// File: rtl/sb_pkg.sv
package sb_pkg;
  localparam int DW     = 32;
  localparam int PORTW  = 5;
  localparam int MODEW  = 2;
  localparam int MISCW  = DW - MODEW;

  // word addresses
  localparam int A_BYP0  = 0;
  localparam int A_BYP1  = 1;
  localparam int A_VP    = 2;
  localparam int A_ISTAT = 3;
  localparam int A_IMASK = 4;
  localparam int A_CTX   = 8;

  // second bypass word keeps only bits 10:0
  localparam int BYP1W   = 11;

  // field bit positions that neighbours decode
  localparam int CTX_PORT_LSB = 9;

  typedef struct packed {
    logic             en;
    logic [PORTW-1:0] port_in;
  } in_stage_t;

  typedef struct packed {
    logic [5:0]       vblank;
    logic [7:0]       hblank;
    logic [16:0]      pclk;
    logic             dup;
    logic [PORTW-1:0] port_out;
  } out_stage_t;
endpackage

// File: rtl/sb_latch.sv
module sb_latch #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= d;
  end
endmodule

// File: rtl/sb_prog_regs.sv
module sb_prog_regs
  import sb_pkg::*;
#(
  parameter int NCTX = 4,
  parameter int AW   = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      we,
  input  logic [AW-1:0]             waddr,
  input  logic [DW-1:0]             wdata,
  output logic [DW-1:0]             byp0,
  output logic [BYP1W-1:0]          byp1,
  output logic [DW-1:0]             vp,
  output logic [NCTX-1:0][DW-1:0]   ctx
);
  logic hit_b0, hit_b1, hit_vp;

  assign hit_b0 = we && (waddr == AW'(A_BYP0));
  assign hit_b1 = we && (waddr == AW'(A_BYP1));
  assign hit_vp = we && (waddr == AW'(A_VP));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      byp0 <= '0;
      byp1 <= '0;
      vp   <= '0;
    end else begin
      if (hit_b0) byp0 <= wdata;
      if (hit_b1) byp1 <= wdata[BYP1W-1:0];
      if (hit_vp) vp   <= wdata;
    end
  end

  for (genvar k = 0; k < NCTX; k++) begin : g_ctx
    logic hit;
    assign hit = we && (waddr == AW'(A_CTX + k));
    always_ff @(posedge clk) begin
      if (!rst_n)   ctx[k] <= '0;
      else if (hit) ctx[k] <= wdata;
    end
  end
endmodule

// File: rtl/sb_irq.sv
module sb_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  input  logic mask_we,
  input  logic mask_d,
  output logic stat,
  output logic mask,
  output logic irq
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat <= 1'b0;
      mask <= 1'b0;
    end else begin
      if (set)      stat <= 1'b1;
      else if (clr) stat <= 1'b0;
      if (mask_we)  mask <= mask_d;
    end
  end

  assign irq = stat & mask;
endmodule

// File: rtl/sb_readmux.sv
module sb_readmux
  import sb_pkg::*;
#(
  parameter int NCTX = 4,
  parameter int AW   = 4
) (
  input  logic [AW-1:0]           addr,
  input  logic [DW-1:0]           w_byp0,
  input  logic [DW-1:0]           w_byp1,
  input  logic [DW-1:0]           w_vp,
  input  logic [DW-1:0]           w_stat,
  input  logic [DW-1:0]           w_mask,
  input  logic [NCTX-1:0][DW-1:0] w_ctx,
  output logic [DW-1:0]           rdata
);
  always_comb begin
    rdata = '0;
    if (addr == AW'(A_BYP0))  rdata = w_byp0;
    if (addr == AW'(A_BYP1))  rdata = w_byp1;
    if (addr == AW'(A_VP))    rdata = w_vp;
    if (addr == AW'(A_ISTAT)) rdata = w_stat;
    if (addr == AW'(A_IMASK)) rdata = w_mask;
    for (int k = 0; k < NCTX; k++) begin
      if (addr == AW'(A_CTX + k)) rdata = w_ctx[k];
    end
  end
endmodule

// File: rtl/shadow_bank.sv
module shadow_bank
  import sb_pkg::*;
#(
  parameter int NCTX = 4,
  parameter int AW   = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  reg_we,
  input  logic [AW-1:0]         reg_waddr,
  input  logic [31:0]           reg_wdata,
  input  logic [AW-1:0]         reg_raddr,
  output logic [31:0]           reg_rdata,
  input  logic [AW-1:0]         dbg_raddr,
  output logic [31:0]           dbg_rdata,
  input  logic                  fs_in,
  input  logic                  fs_out,
  input  logic                  fs_vp,
  input  logic                  fs_tag_vld,
  input  logic [4:0]            fs_tag_port,
  input  logic                  fs_early,
  output logic                  byp_en,
  output logic [4:0]            byp_port_in,
  output logic [5:0]            byp_vblank,
  output logic [7:0]            byp_hblank,
  output logic [16:0]           byp_pclk,
  output logic                  byp_dup,
  output logic [4:0]            byp_port_out,
  output logic [30:0]           vp_cfg,
  output logic                  vp_fs_reset,
  output logic [2*NCTX-1:0]     ctx_mode,
  output logic [30*NCTX-1:0]    ctx_misc,
  output logic                  irq
);
  localparam int INW  = $bits(in_stage_t);
  localparam int OUTW = $bits(out_stage_t);
  localparam int VPW  = DW - 1;

  // programmed (software side) copies
  logic [DW-1:0]           p_byp0;
  logic [BYP1W-1:0]        p_byp1;
  logic [DW-1:0]           p_vp;
  logic [NCTX-1:0][DW-1:0] p_ctx;
  logic                    irq_stat, irq_mask;

  sb_prog_regs #(.NCTX(NCTX), .AW(AW)) u_prog (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (reg_we),
    .waddr (reg_waddr),
    .wdata (reg_wdata),
    .byp0  (p_byp0),
    .byp1  (p_byp1),
    .vp    (p_vp),
    .ctx   (p_ctx)
  );

  sb_irq u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .set     (fs_early),
    .clr     (reg_we && (reg_waddr == AW'(A_ISTAT)) && reg_wdata[0]),
    .mask_we (reg_we && (reg_waddr == AW'(A_IMASK))),
    .mask_d  (reg_wdata[0]),
    .stat    (irq_stat),
    .mask    (irq_mask),
    .irq     (irq)
  );

  // input-stage group: enable and input port
  in_stage_t in_d, in_q;
  assign in_d.en      = p_byp0[31];
  assign in_d.port_in = p_byp1[4:0];

  sb_latch #(.W(INW)) u_in_stage (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (fs_in),
    .d     (in_d),
    .q     (in_q)
  );

  // output-stage group: blanking, divider, duplicate, output port
  out_stage_t out_d, out_q;
  assign out_d.vblank   = p_byp0[30:25];
  assign out_d.hblank   = p_byp0[24:17];
  assign out_d.pclk     = p_byp0[16:0];
  assign out_d.dup      = p_byp1[10];
  assign out_d.port_out = p_byp1[9:5];

  sb_latch #(.W(OUTW)) u_out_stage (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (fs_out),
    .d     (out_d),
    .q     (out_q)
  );

  // video port group; bit 31 stays immediate
  logic [VPW-1:0] vp_q;

  sb_latch #(.W(VPW)) u_vp_stage (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (fs_vp),
    .d     (p_vp[VPW-1:0]),
    .q     (vp_q)
  );

  // write contexts: mode loads on a tag matching the context's own port
  logic [NCTX-1:0][MODEW-1:0] mode_q;
  logic [NCTX-1:0][DW-1:0]    dbg_ctx;

  for (genvar k = 0; k < NCTX; k++) begin : g_ctx
    logic match;
    assign match = fs_tag_vld &&
                   (fs_tag_port == p_ctx[k][CTX_PORT_LSB +: PORTW]);

    sb_latch #(.W(MODEW)) u_mode (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (match),
      .d     (p_ctx[k][MODEW-1:0]),
      .q     (mode_q[k])
    );

    assign ctx_mode[k*MODEW +: MODEW] = mode_q[k];
    assign ctx_misc[k*MISCW +: MISCW] = p_ctx[k][DW-1:MODEW];
    assign dbg_ctx[k]                 = {p_ctx[k][DW-1:MODEW], mode_q[k]};
  end

  assign byp_en       = in_q.en;
  assign byp_port_in  = in_q.port_in;
  assign byp_vblank   = out_q.vblank;
  assign byp_hblank   = out_q.hblank;
  assign byp_pclk     = out_q.pclk;
  assign byp_dup      = out_q.dup;
  assign byp_port_out = out_q.port_out;
  assign vp_cfg       = vp_q;
  assign vp_fs_reset  = p_vp[DW-1];

  // software readback of programmed values
  sb_readmux #(.NCTX(NCTX), .AW(AW)) u_rd_prog (
    .addr   (reg_raddr),
    .w_byp0 (p_byp0),
    .w_byp1 ({{(DW-BYP1W){1'b0}}, p_byp1}),
    .w_vp   (p_vp),
    .w_stat ({{(DW-1){1'b0}}, irq_stat}),
    .w_mask ({{(DW-1){1'b0}}, irq_mask}),
    .w_ctx  (p_ctx),
    .rdata  (reg_rdata)
  );

  // debug readback of working values
  sb_readmux #(.NCTX(NCTX), .AW(AW)) u_rd_work (
    .addr   (dbg_raddr),
    .w_byp0 ({in_q.en, out_q.vblank, out_q.hblank, out_q.pclk}),
    .w_byp1 ({{(DW-BYP1W){1'b0}}, out_q.dup, out_q.port_out, in_q.port_in}),
    .w_vp   ({p_vp[DW-1], vp_q}),
    .w_stat ('0),
    .w_mask ('0),
    .w_ctx  (dbg_ctx),
    .rdata  (dbg_rdata)
  );
endmodule

// File: rtl/shadow_bank_chk.sv
module shadow_bank_chk #(
  parameter int NCTX = 4,
  parameter int AW   = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_we,
  input logic [AW-1:0]     reg_waddr,
  input logic [31:0]       reg_wdata,
  input logic              fs_in,
  input logic              fs_out,
  input logic              fs_vp,
  input logic              fs_tag_vld,
  input logic [4:0]        fs_tag_port,
  input logic              fs_early,
  input logic              byp_en,
  input logic [4:0]        byp_port_in,
  input logic [5:0]        byp_vblank,
  input logic [7:0]        byp_hblank,
  input logic [16:0]       byp_pclk,
  input logic              byp_dup,
  input logic [4:0]        byp_port_out,
  input logic [30:0]       vp_cfg,
  input logic              vp_fs_reset,
  input logic [2*NCTX-1:0] ctx_mode,
  input logic [30*NCTX-1:0] ctx_misc,
  input logic              irq_stat,
  input logic              irq_mask,
  input logic              irq
);
  p_fsreset_now_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_waddr == AW'(2)) |=> (vp_fs_reset == $past(reg_wdata[31])));

  p_in_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !fs_in |=> $stable({byp_en, byp_port_in}));

  p_out_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !fs_out |=> $stable({byp_vblank, byp_hblank, byp_pclk, byp_dup, byp_port_out}));

  p_vp_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !fs_vp |=> $stable(vp_cfg));

  for (genvar k = 0; k < NCTX; k++) begin : g_ctx
    p_mode_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !(fs_tag_vld && fs_tag_port == ctx_misc[k*30+7 +: 5]) |=> $stable(ctx_mode[2*k +: 2]));
  end

  p_irq_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fs_early |=> irq_stat);

  p_irq_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!fs_early && reg_we && reg_waddr == AW'(3) && reg_wdata[0]) |=> !irq_stat);

  p_irq_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_mask |-> !irq);
endmodule

bind shadow_bank shadow_bank_chk #(.NCTX(NCTX), .AW(AW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .reg_we       (reg_we),
  .reg_waddr    (reg_waddr),
  .reg_wdata    (reg_wdata),
  .fs_in        (fs_in),
  .fs_out       (fs_out),
  .fs_vp        (fs_vp),
  .fs_tag_vld   (fs_tag_vld),
  .fs_tag_port  (fs_tag_port),
  .fs_early     (fs_early),
  .byp_en       (byp_en),
  .byp_port_in  (byp_port_in),
  .byp_vblank   (byp_vblank),
  .byp_hblank   (byp_hblank),
  .byp_pclk     (byp_pclk),
  .byp_dup      (byp_dup),
  .byp_port_out (byp_port_out),
  .vp_cfg       (vp_cfg),
  .vp_fs_reset  (vp_fs_reset),
  .ctx_mode     (ctx_mode),
  .ctx_misc     (ctx_misc),
  .irq_stat     (irq_stat),
  .irq_mask     (irq_mask),
  .irq          (irq)
);

// File: tb/sim_shadow_bank.sv
module sim_shadow_bank;
  localparam int NCTX = 4;
  localparam int AW   = 4;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic              rst_n;
  logic              reg_we;
  logic [AW-1:0]     reg_waddr, reg_raddr, dbg_raddr;
  logic [31:0]       reg_wdata, reg_rdata, dbg_rdata;
  logic              fs_in, fs_out, fs_vp, fs_tag_vld, fs_early;
  logic [4:0]        fs_tag_port;
  logic              byp_en, byp_dup, vp_fs_reset, irq;
  logic [4:0]        byp_port_in, byp_port_out;
  logic [5:0]        byp_vblank;
  logic [7:0]        byp_hblank;
  logic [16:0]       byp_pclk;
  logic [30:0]       vp_cfg;
  logic [2*NCTX-1:0] ctx_mode;
  logic [30*NCTX-1:0] ctx_misc;

  shadow_bank #(.NCTX(NCTX), .AW(AW)) u0 (.*);

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  // bench model: programmed and working copies
  logic [31:0] m_b0, m_b1, m_vp;
  logic [31:0] m_ctx [NCTX];
  logic        m_stat, m_mask;
  logic        w_en;
  logic [4:0]  w_pin;
  logic [30:0] w_bo;
  logic [5:0]  w_b1o;
  logic [30:0] w_vp;
  logic [1:0]  w_mode [NCTX];

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_prog(logic [AW-1:0] a);
    logic [31:0] r = '0;
    if (a == 0) r = m_b0;
    if (a == 1) r = {21'b0, m_b1[10:0]};
    if (a == 2) r = m_vp;
    if (a == 3) r = {31'b0, m_stat};
    if (a == 4) r = {31'b0, m_mask};
    for (int k = 0; k < NCTX; k++) if (a == AW'(8 + k)) r = m_ctx[k];
    return r;
  endfunction

  function automatic logic [31:0] exp_work(logic [AW-1:0] a);
    logic [31:0] r = '0;
    if (a == 0) r = {w_en, w_bo};
    if (a == 1) r = {21'b0, w_b1o, w_pin};
    if (a == 2) r = {m_vp[31], w_vp};
    for (int k = 0; k < NCTX; k++) if (a == AW'(8 + k)) r = {m_ctx[k][31:2], w_mode[k]};
    return r;
  endfunction

  task automatic model_reset();
    m_b0 = '0; m_b1 = '0; m_vp = '0; m_stat = 0; m_mask = 0;
    w_en = 0; w_pin = '0; w_bo = '0; w_b1o = '0; w_vp = '0;
    for (int k = 0; k < NCTX; k++) begin m_ctx[k] = '0; w_mode[k] = '0; end
  endtask

  // one clock edge of the model, from pre-edge state and held inputs
  task automatic model_step();
    if (!rst_n) begin model_reset(); return; end
    if (fs_in)  begin w_en = m_b0[31]; w_pin = m_b1[4:0]; end
    if (fs_out) begin w_bo = m_b0[30:0]; w_b1o = m_b1[10:5]; end
    if (fs_vp)  w_vp = m_vp[30:0];
    if (fs_tag_vld)
      for (int k = 0; k < NCTX; k++)
        if (fs_tag_port == m_ctx[k][13:9]) w_mode[k] = m_ctx[k][1:0];
    if (fs_early) m_stat = 1;
    else if (reg_we && reg_waddr == 3 && reg_wdata[0]) m_stat = 0;
    if (reg_we) begin
      if (reg_waddr == 0) m_b0 = reg_wdata;
      if (reg_waddr == 1) m_b1 = {21'b0, reg_wdata[10:0]};
      if (reg_waddr == 2) m_vp = reg_wdata;
      if (reg_waddr == 4) m_mask = reg_wdata[0];
      for (int k = 0; k < NCTX; k++) if (reg_waddr == AW'(8 + k)) m_ctx[k] = reg_wdata;
    end
  endtask

  task automatic compare_all();
    chk("R2 byp_en", byp_en, w_en);
    chk("R2 byp_port_in", byp_port_in, w_pin);
    chk("R3 blank/pclk", {byp_vblank, byp_hblank, byp_pclk}, w_bo);
    chk("R3 dup/port_out", {byp_dup, byp_port_out}, w_b1o);
    chk("R4 vp_cfg", vp_cfg, w_vp);
    chk("R1 vp_fs_reset", vp_fs_reset, m_vp[31]);
    for (int k = 0; k < NCTX; k++) begin
      chk("R5 ctx_mode", ctx_mode[2*k +: 2], w_mode[k]);
      chk("R1 ctx_misc", ctx_misc[30*k +: 30], m_ctx[k][31:2]);
    end
    chk("R8 irq", irq, m_stat & m_mask);
    chk("R7 reg_rdata", reg_rdata, exp_prog(reg_raddr));
    chk("R7 dbg_rdata", dbg_rdata, exp_work(dbg_raddr));
  endtask

  task automatic idle_inputs();
    reg_we = 0; reg_waddr = '0; reg_wdata = '0;
    fs_in = 0; fs_out = 0; fs_vp = 0; fs_tag_vld = 0; fs_tag_port = '0; fs_early = 0;
  endtask

  task automatic run();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare_all();
    idle_inputs();
  endtask

  task automatic wr(logic [AW-1:0] a, logic [31:0] d);
    reg_we = 1; reg_waddr = a; reg_wdata = d;
  endtask

  initial begin
    for (int c = 0; c < 200000; c++) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    idle_inputs();
    reg_raddr = '0; dbg_raddr = '0;
    rst_n = 0;
    model_reset();
    repeat (3) run();
    // R9: reset state
    chk("R9 reset rdata", reg_rdata, 32'h0);
    chk("R9 reset byp_en", byp_en, 1'b0);
    @(negedge clk);
    rst_n = 1;

    // R9/R2: programming without an FS changes no working copy
    wr(0, 32'hFFFF_FFFF); run();
    chk("R9 no load before FS", {byp_en, byp_pclk}, 18'h0);
    // R6: write and FS in the same cycle keep the old value
    fs_in = 1; fs_out = 1; wr(0, 32'h0); run();
    chk("R6 collision en", byp_en, 1'b1);
    chk("R6 collision pclk", byp_pclk, 17'h1FFFF);
    // R2 vs R3: input FS alone leaves output-stage fields
    fs_in = 1; run();
    chk("R2 en reloaded", byp_en, 1'b0);
    chk("R3 pclk kept", byp_pclk, 17'h1FFFF);

    // R5: tag must match the context's own port field
    wr(8, (32'd3 << 9) | 32'h2); run();
    fs_tag_vld = 1; fs_tag_port = 5'd4; run();
    chk("R5 mismatch ignored", ctx_mode[1:0], 2'b00);
    fs_tag_vld = 1; fs_tag_port = 5'd3; run();
    chk("R5 match loads", ctx_mode[1:0], 2'b10);

    // R8: set wins over W1C in the same cycle, then clear
    wr(4, 32'h1); run();
    fs_early = 1; run();
    chk("R8 irq raised", irq, 1'b1);
    fs_early = 1; wr(3, 32'h1); run();
    chk("R8 set wins", irq, 1'b1);
    wr(3, 32'h1); run();
    chk("R8 cleared", irq, 1'b0);

    // R1: immediate bits during FS activity
    fs_vp = 1; wr(2, 32'h8000_0005); run();
    chk("R1 fs_reset immediate", vp_fs_reset, 1'b1);
    chk("R4 vp old value", vp_cfg, 31'h0);

    // random phase
    for (int i = 0; i < 4000; i++) begin
      int unsigned sel;
      if ($urandom % 3 == 0) begin
        sel = $urandom % 10;
        reg_we = 1;
        reg_waddr = (sel < 5) ? AW'(sel) : (sel < 9) ? AW'(8 + (sel - 5)) : AW'(5);
        reg_wdata = $urandom;
      end
      fs_in    = ($urandom % 6 == 0);
      fs_out   = ($urandom % 6 == 0);
      fs_vp    = ($urandom % 6 == 0);
      fs_early = ($urandom % 8 == 0);
      fs_tag_vld = ($urandom % 5 == 0);
      fs_tag_port = ($urandom % 2 == 0) ? m_ctx[$urandom % NCTX][13:9] : 5'($urandom);
      reg_raddr = AW'($urandom);
      dbg_raddr = AW'($urandom);
      run();
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule